// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the read-only status word of a serial port and decides when each flag in it is set or cleared. The transmit and receive datapaths report single-cycle events to it: a character moved from the transmit holding register into the shifter, a received character moved into the receive holding register with any error indications, start-bit and stop-bit progress, and receive overflow. The CPU side reports status reads, transmit register writes and receive register reads.

A flag is cleared only by a two-step software sequence. The status word is read while the flag is 1, and the matching data register access follows later. Each flag has an arm bit that records the first step. A set event in the cycle of the second step takes precedence, so no event is lost. Once the overrun flag is 1, the receive holding register takes no further characters until software clears the overrun. The block also pulses an interrupt request when a character is accepted and the receive interrupt is enabled.

Top module: `uart_stat_top`

## Requirements
- R1: Status bit 0 (transmit empty) becomes 1 on the clock edge after a `txLoad` strobe, and on the clock edge after `txEnable` rises from 0 to 1.
- R2: Bit 0 goes to 0 only on a `txWrite` that follows an earlier `statusRead` taken while bit 0 was 1. A `txWrite` without that earlier read leaves it at 1.
- R3: Status bit 1 (transmit complete) is set one edge after a cycle in which bit 0 is 1, bit 0 is not being cleared, and `txBusy` is 0. It stays 0 while bit 0 is 0, which means a character is queued.
- R4: Bit 1 goes to 0 through the same read-then-`txWrite` sequence, tracked on its own arm bit.
- R5: Status bit 2 (receive full) becomes 1 on the edge after an accepted `rxXfer`. `irq` is 1 for exactly that one cycle when `rxIntEn` was 1 with the transfer. An `rxXfer` is accepted when bit 4 is 0 and `rxOverflow` is 0.
- R6: Bit 2 goes to 0 on an `rxRead` that follows a `statusRead` taken while bit 2 was 1, and only if `rxMoreData` is 0 at that `rxRead`. The `rxRead` uses up the arm bit in either case.
- R7: Bit 6 (noise), bit 5 (framing) and bit 7 (parity) are set on the same edge as bit 2 when `rxNoise`, `rxFrame` or `rxParity` comes with an accepted transfer.
- R8: The noise flag is not set by an `rxXfer` that comes with `rxOverflow`.
- R9: Bit 4 (overrun) becomes 1 after an `rxOverflow` strobe. While it is 1, an `rxXfer` changes neither bit 2 nor the error bits.
- R10: Bits 4, 5, 6 and 7 each go to 0 on an `rxRead` that follows a `statusRead` taken while that bit was 1.
- R11: Bit 3 (receiver idle) is 0 from the edge after `rxStart` until the edge after `rxStopDone`, and 1 at all other times. If both strobes come in the same cycle, `rxStart` wins.
- R12: If a flag's set event and its clear sequence complete in the same cycle, the flag stays 1.
- R13: After reset the status word is 8'h08, with only receiver idle set, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmitter enable level |
| rxIntEn | input | 1 | Receive interrupt enable level |
| txLoad | input | 1 | Shifter took the transmit holding register |
| txBusy | input | 1 | Character or break being shifted out |
| rxXfer | input | 1 | Received character moved to holding register |
| rxNoise | input | 1 | Noise seen on the transferred character |
| rxFrame | input | 1 | Bad stop bit on the transferred character |
| rxParity | input | 1 | Parity mismatch on the transferred character |
| rxOverflow | input | 1 | Receive buffer overflow event |
| rxStart | input | 1 | Start bit detected |
| rxStopDone | input | 1 | Stop bit completed |
| rxMoreData | input | 1 | Further received data still waiting |
| statusRead | input | 1 | CPU reads the status word |
| txWrite | input | 1 | CPU writes the transmit holding register |
| rxRead | input | 1 | CPU reads the receive holding register |
| status | output | 8 | Status word |
| irq | output | 1 | Receive interrupt request pulse |

## Verification
On every cycle, the assertions check the invariants. A flag that is not armed cannot drop. Transmit complete cannot appear while a character is queued. Overrun blocks receive full. An overflowing transfer never raises noise. Start-bit detection forces the receiver busy, and `irq` only comes with receive full. The directed scenarios are needed for the rest. They show the full two-step clear sequences and the check of `rxMoreData` on the receive read. They also cover precedence of a set over a clear in the same cycle, and the exact cycle in which each flag and the interrupt pulse appear.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  parameter int STATUS_W = 8;
  localparam int TX_EMPTY = 0;
  localparam int TX_DONE  = 1;
  localparam int RX_FULL  = 2;
  localparam int RX_IDLE  = 3;
  localparam int OVERRUN  = 4;
  localparam int FRAME    = 5;
  localparam int NOISE    = 6;
  localparam int PARITY   = 7;
  localparam logic [STATUS_W-1:0] RESET_WORD = STATUS_W'(1) << RX_IDLE;

  typedef struct packed {
    logic [STATUS_W-1:0] set;
    logic [STATUS_W-1:0] clr;
    logic                irqPulse;
  } flagStrobes_t;
endpackage

// File: rtl/uart_stat_ctrl.sv
module uart_stat_ctrl
  import uart_stat_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEnable,
  input  logic                rxIntEn,
  input  logic                txLoad,
  input  logic                txBusy,
  input  logic                rxXfer,
  input  logic                rxNoise,
  input  logic                rxFrame,
  input  logic                rxParity,
  input  logic                rxOverflow,
  input  logic                rxStart,
  input  logic                rxStopDone,
  input  logic                rxMoreData,
  input  logic                statusRead,
  input  logic                txWrite,
  input  logic                rxRead,
  input  logic [STATUS_W-1:0] flagQ,
  output flagStrobes_t        strb
);
  logic                enPrev;
  logic [STATUS_W-1:0] armQ;
  logic [STATUS_W-1:0] access;
  logic [STATUS_W-1:0] clrV;
  logic [STATUS_W-1:0] setV;
  logic                accepted;

  assign accepted = rxXfer && !flagQ[OVERRUN] && !rxOverflow;

  always_ff @(posedge clk) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= txEnable;
  end

  // Set events for every flag
  always_comb begin
    setV           = '0;
    setV[TX_EMPTY] = txLoad || (txEnable && !enPrev);
    setV[TX_DONE]  = flagQ[TX_EMPTY] && !clrV[TX_EMPTY] && !txBusy;
    setV[RX_FULL]  = accepted;
    setV[NOISE]    = accepted && rxNoise;
    setV[FRAME]    = accepted && rxFrame;
    setV[PARITY]   = accepted && rxParity;
    setV[OVERRUN]  = rxOverflow;
    setV[RX_IDLE]  = rxStopDone && !rxStart;
  end

  // Two-step clear sequence per flag
  for (genvar i = 0; i < STATUS_W; i++) begin : g_arm
    if (i == RX_IDLE) begin : g_idle
      assign access[i] = 1'b0;
      assign armQ[i]   = 1'b0;
      assign clrV[i]   = rxStart;
    end else begin : g_seq
      if (i == TX_EMPTY || i == TX_DONE) begin : g_tx
        assign access[i] = txWrite;
      end else begin : g_rx
        assign access[i] = rxRead;
      end
      logic armR;
      always_ff @(posedge clk) begin
        if (!rstN)                        armR <= 1'b0;
        else if (access[i])               armR <= 1'b0;
        else if (statusRead && flagQ[i])  armR <= 1'b1;
      end
      assign armQ[i] = armR;
      if (i == RX_FULL) begin : g_full
        assign clrV[i] = access[i] && armR && !rxMoreData;
      end else begin : g_plain
        assign clrV[i] = access[i] && armR;
      end
    end
  end

  assign strb.set      = setV;
  assign strb.clr      = clrV;
  assign strb.irqPulse = accepted && rxIntEn;

  // R2: an unarmed transmit-empty flag cannot drop
  a_r2_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    flagQ[TX_EMPTY] && !armQ[TX_EMPTY] |=> flagQ[TX_EMPTY]);
  // R6: an unarmed receive-full flag cannot drop
  a_r6_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    flagQ[RX_FULL] && !armQ[RX_FULL] |=> flagQ[RX_FULL]);
  // R10: an unarmed framing flag cannot drop
  a_r10_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    flagQ[FRAME] && !armQ[FRAME] |=> flagQ[FRAME]);
endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
  import uart_stat_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  flagStrobes_t        strb,
  output logic [STATUS_W-1:0] flagQ,
  output logic                irq
);
  for (genvar i = 0; i < STATUS_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)            flagQ[i] <= RESET_WORD[i];
      else if (strb.set[i]) flagQ[i] <= 1'b1;
      else if (strb.clr[i]) flagQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= strb.irqPulse;
  end

  // R12: a set strobe always leaves the flag at 1
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.set[RX_FULL] |=> flagQ[RX_FULL]);
  // R11: start detection makes the receiver busy
  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr[RX_IDLE] |=> !flagQ[RX_IDLE]);
endmodule

// File: rtl/uart_stat_top.sv
module uart_stat_top
  import uart_stat_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEnable,
  input  logic                rxIntEn,
  input  logic                txLoad,
  input  logic                txBusy,
  input  logic                rxXfer,
  input  logic                rxNoise,
  input  logic                rxFrame,
  input  logic                rxParity,
  input  logic                rxOverflow,
  input  logic                rxStart,
  input  logic                rxStopDone,
  input  logic                rxMoreData,
  input  logic                statusRead,
  input  logic                txWrite,
  input  logic                rxRead,
  output logic [STATUS_W-1:0] status,
  output logic                irq
);
  flagStrobes_t        strb;
  logic [STATUS_W-1:0] flagQ;

  uart_stat_ctrl i_ctrl (
    .clk, .rstN, .txEnable, .rxIntEn, .txLoad, .txBusy, .rxXfer, .rxNoise,
    .rxFrame, .rxParity, .rxOverflow, .rxStart, .rxStopDone, .rxMoreData,
    .statusRead, .txWrite, .rxRead, .flagQ, .strb
  );

  uart_stat_flags i_flags (.clk, .rstN, .strb, .flagQ, .irq);

  assign status = flagQ;

  // R3: transmit complete cannot appear while a character is queued
  a_r3_no_done_queued: assert property (@(posedge clk) disable iff (!rstN)
    !status[TX_EMPTY] && !status[TX_DONE] |=> !status[TX_DONE]);
  // R9: overrun blocks new receive data
  a_r9_overrun_blocks: assert property (@(posedge clk) disable iff (!rstN)
    status[OVERRUN] && !status[RX_FULL] |=> !status[RX_FULL]);
  // R8: an overflowing transfer never raises noise
  a_r8_no_noise_ovf: assert property (@(posedge clk) disable iff (!rstN)
    rxXfer && rxOverflow && !status[NOISE] |=> !status[NOISE]);
  // R5: interrupt pulse only with receive full
  a_r5_irq_full: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> status[RX_FULL]);
endmodule

// File: tb/test_uart_stat_top.sv
module test_uart_stat_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 0, rxIntEn = 0, txLoad = 0, txBusy = 0, rxXfer = 0;
  logic rxNoise = 0, rxFrame = 0, rxParity = 0, rxOverflow = 0;
  logic rxStart = 0, rxStopDone = 0, rxMoreData = 0;
  logic statusRead = 0, txWrite = 0, rxRead = 0;
  logic [7:0] status;
  logic irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_stat_top i_uart_stat_top (
    .clk, .rstN, .txEnable, .rxIntEn, .txLoad, .txBusy, .rxXfer, .rxNoise,
    .rxFrame, .rxParity, .rxOverflow, .rxStart, .rxStopDone, .rxMoreData,
    .statusRead, .txWrite, .rxRead, .status, .irq
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic clearStrobes();
    txLoad = 0; rxXfer = 0; rxNoise = 0; rxFrame = 0; rxParity = 0;
    rxOverflow = 0; rxStart = 0; rxStopDone = 0; statusRead = 0;
    txWrite = 0; rxRead = 0;
  endtask

  task automatic testReset();
    check("R13 reset word", status, 8'h08);
    check("R13 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic testTransmit();
    txEnable = 1; tick();
    check("R1 empty after enable", {7'b0, status[0]}, 8'h01);
    check("R3 done waits a cycle", {7'b0, status[1]}, 8'h00);
    tick();
    check("R3 done sets", {7'b0, status[1]}, 8'h01);
    txWrite = 1; tick(); clearStrobes();
    check("R2 unarmed write ignored", {6'b0, status[1:0]}, 8'h03);
    statusRead = 1; tick(); clearStrobes();
    txWrite = 1; tick(); clearStrobes();
    check("R2 R4 cleared by sequence", {6'b0, status[1:0]}, 8'h00);
    tick(); tick(); tick();
    check("R3 no done while queued", {6'b0, status[1:0]}, 8'h00);
    txLoad = 1; txBusy = 1; tick(); clearStrobes();
    check("R1 empty after load", {6'b0, status[1:0]}, 8'h01);
    tick();
    check("R3 no done while busy", {7'b0, status[1]}, 8'h00);
    txBusy = 0; tick();
    check("R3 done after busy ends", {7'b0, status[1]}, 8'h01);
  endtask

  task automatic testReceive();
    rxStart = 1; tick(); clearStrobes();
    check("R11 busy after start", {7'b0, status[3]}, 8'h00);
    rxStopDone = 1; tick(); clearStrobes();
    check("R11 idle after stop", {7'b0, status[3]}, 8'h01);
    rxStart = 1; rxStopDone = 1; tick(); clearStrobes();
    check("R11 start wins", {7'b0, status[3]}, 8'h00);
    rxStopDone = 1; tick(); clearStrobes();
    rxIntEn = 1; rxXfer = 1; rxNoise = 1; rxFrame = 1; rxParity = 1;
    tick(); clearStrobes();
    check("R5 R7 full and errors", status & 8'hF4, 8'hE4);
    check("R5 irq pulse", {7'b0, irq}, 8'h01);
    tick();
    check("R5 irq one cycle", {7'b0, irq}, 8'h00);
    rxRead = 1; tick(); clearStrobes();
    check("R6 R10 unarmed read ignored", status & 8'hF4, 8'hE4);
    statusRead = 1; tick(); clearStrobes();
    rxMoreData = 1; rxRead = 1; tick(); clearStrobes(); rxMoreData = 0;
    check("R6 R10 full kept, errors cleared", status & 8'hF4, 8'h04);
    rxRead = 1; tick(); clearStrobes();
    check("R6 arm used up", {7'b0, status[2]}, 8'h01);
    statusRead = 1; tick(); clearStrobes();
    rxRead = 1; tick(); clearStrobes();
    check("R6 full cleared", {7'b0, status[2]}, 8'h00);
  endtask

  task automatic testOverrun();
    rxIntEn = 0; rxXfer = 1; tick(); clearStrobes();
    check("R5 no irq when disabled", {7'b0, irq}, 8'h00);
    rxXfer = 1; rxOverflow = 1; rxNoise = 1; tick(); clearStrobes();
    check("R8 R9 overrun no noise", status & 8'h54, 8'h14);
    statusRead = 1; tick(); clearStrobes();
    rxRead = 1; tick(); clearStrobes();
    check("R10 overrun and full cleared", status & 8'h14, 8'h00);
    rxOverflow = 1; tick(); clearStrobes();
    check("R9 overrun set", {7'b0, status[4]}, 8'h01);
    rxXfer = 1; rxFrame = 1; tick(); clearStrobes();
    check("R9 transfer inhibited", status & 8'h24, 8'h00);
    statusRead = 1; tick(); clearStrobes();
    rxRead = 1; tick(); clearStrobes();
    check("R10 overrun cleared", {7'b0, status[4]}, 8'h00);
  endtask

  task automatic testPriority();
    rxXfer = 1; tick(); clearStrobes();
    statusRead = 1; tick(); clearStrobes();
    rxRead = 1; rxXfer = 1; tick(); clearStrobes();
    check("R12 set beats clear", {7'b0, status[2]}, 8'h01);
  endtask

  initial begin
    tick(); tick();
    testReset();
    rstN = 1; tick();
    testReset();
    testTransmit();
    testReceive();
    testOverrun();
    testPriority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule